// File: doc/BRIEF.md
# Register-Immediate Integer Execute Stage

This block is the execute stage for the 32-bit base integer instructions that combine a source register with a 12-bit immediate. Each cycle it may receive one instruction word, with a valid flag, the address of that instruction and the value already read from the first source register. It decodes the minor operation fields and builds the sign-extended immediate and the shift amount. One clock later it presents the result, the destination register index and a write enable for the register file.

The stage claims only the register-immediate major opcode (binary 0010011). Words with any other opcode pass through without effect, because another unit handles them. A claimed word whose shift-control field holds a value that is not defined raises a precise illegal-instruction trap. The trap carries the instruction's address and raw word, and the stage suppresses writeback for that instruction. A downstream trap handler takes over from there.

Top module: `imm_alu_stage`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs have `out_valid`, `out_wen` and `out_trap` all low, whatever the inputs are.
- R2: The minor code in bits [14:12] equal to 000 adds rs1 to the immediate (instruction bits [31:20] sign-extended to 32 bits), wrapping modulo 2^32. The result appears on the clock edge after the input is accepted.
- R3: Minor code 010 yields 1 when rs1 is below the sign-extended immediate in two's-complement order, and 0 otherwise.
- R4: Minor code 011 yields 1 when rs1 is below the sign-extended immediate, both read as unsigned 32-bit numbers, and 0 otherwise.
- R5: Minor codes 100, 110 and 111 give the bitwise XOR, OR and AND of rs1 with the sign-extended immediate.
- R6: Minor code 001 with bits [31:25] equal to 0000000 shifts rs1 left by bits [24:20]. The vacated bits are zero.
- R7: Minor code 101 shifts rs1 right by bits [24:20]. Bits [31:25] equal to 0000000 fill with zeros, and 0100000 fills with copies of rs1 bit 31.
- R8: Under minor code 001, bits [31:25] other than 0000000 are illegal. Under minor code 101, bits [31:25] other than 0000000 or 0100000 are illegal. An illegal word sets `out_valid` and `out_trap`, keeps `out_wen` low, and presents its address and raw word on `out_trap_pc` and `out_trap_instr`.
- R9: A valid input whose bits [6:0] differ from 0010011 produces no `out_valid`, no `out_wen` and no `out_trap` on the next cycle.
- R10: A legal instruction whose destination (bits [11:7]) is 0 still sets `out_valid` and presents its computed result, but keeps `out_wen` low.
- R11: A cycle with `in_valid` low produces no `out_valid`, no `out_wen` and no `out_trap` on the next cycle.
- R12: A legal, accepted instruction sets `out_valid`, keeps `out_trap` low, and presents bits [11:7] on `out_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction word and operands are present this cycle |
| in_instr | input | 32 | Raw instruction word |
| in_pc | input | 32 | Address of the instruction |
| in_rs1_val | input | 32 | Value of the first source register |
| out_valid | output | 1 | A claimed instruction completed (result or trap) |
| out_rd | output | 5 | Destination register index |
| out_wen | output | 1 | Register-file write enable for `out_result` |
| out_result | output | 32 | Computed result |
| out_trap | output | 1 | Illegal-instruction trap for this output |
| out_trap_pc | output | 32 | Address of the trapping instruction |
| out_trap_instr | output | 32 | Raw word of the trapping instruction |

## Verification
The assertions take `in_valid`, `in_instr` and `in_pc` as known, non-X values on every clock edge once reset is released. Several properties refer back to the previous cycle's inputs through `$past`, so an unknown bit there would make them meaningless. The bench always drives all three inputs, including on idle cycles, where it holds a register-immediate opcode with `in_valid` low. It changes inputs only a time step after the rising edge, so each property sees exactly one instruction per cycle.

// File: rtl/imm_alu_pkg.sv
// Package: shared definitions for the register-immediate execute stage.
// Holds the operation selector type and the fixed encoding constants of
// the instruction group. Assumes the 32-bit base instruction format.
package imm_alu_pkg;

    localparam int unsigned ILEN = 32;

    localparam logic [6:0] OPC_REG_IMM = 7'b0010011;
    localparam logic [6:0] F7_PLAIN    = 7'b0000000;
    localparam logic [6:0] F7_ALT      = 7'b0100000;

    localparam logic [2:0] F3_ADD  = 3'b000;
    localparam logic [2:0] F3_SLL  = 3'b001;
    localparam logic [2:0] F3_SLT  = 3'b010;
    localparam logic [2:0] F3_SLTU = 3'b011;
    localparam logic [2:0] F3_XOR  = 3'b100;
    localparam logic [2:0] F3_SHR  = 3'b101;
    localparam logic [2:0] F3_OR   = 3'b110;
    localparam logic [2:0] F3_AND  = 3'b111;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_SLL,
        OP_SLT,
        OP_SLTU,
        OP_XOR,
        OP_SRL,
        OP_SRA,
        OP_OR,
        OP_AND
    } alu_op_e;

endpackage

// File: rtl/imm_alu_decode.sv
// Module: imm_alu_decode
// Splits a raw instruction word into its fields, builds the sign-extended
// immediate and the shift amount, selects the operation and flags encodings
// that are not defined. Purely combinational. Assumes the word is only
// meaningful when the caller also checks `claim`.
module imm_alu_decode
    import imm_alu_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned RIDX_W  = 5,
    localparam int unsigned SHW    = $clog2(XLEN)
) (
    input  logic [ILEN-1:0]   instr,
    output logic              claim,
    output logic              legal,
    output alu_op_e           op,
    output logic [XLEN-1:0]   imm,
    output logic [SHW-1:0]    shamt,
    output logic [RIDX_W-1:0] rd
);

    localparam int unsigned IMM_W = 12;

    logic [6:0] opcode;
    logic [2:0] minor;
    logic [6:0] upper;

    // Field extraction from fixed bit positions of the instruction format.
    always_comb begin
        opcode = instr[6:0];
        minor  = instr[14:12];
        upper  = instr[31:25];
        rd     = instr[7 +: RIDX_W];
        shamt  = instr[20 +: SHW];
        imm    = {{(XLEN-IMM_W){instr[31]}}, instr[31:20]};
        claim  = (opcode == OPC_REG_IMM);
    end

    // Operation selection and legality check from the minor and upper codes.
    always_comb begin
        legal = 1'b1;
        op    = OP_ADD;
        unique case (minor)
            F3_ADD:  op = OP_ADD;
            F3_SLL: begin
                op    = OP_SLL;
                legal = (upper == F7_PLAIN);
            end
            F3_SLT:  op = OP_SLT;
            F3_SLTU: op = OP_SLTU;
            F3_XOR:  op = OP_XOR;
            F3_SHR: begin
                op    = (upper == F7_ALT) ? OP_SRA : OP_SRL;
                legal = (upper == F7_PLAIN) || (upper == F7_ALT);
            end
            F3_OR:   op = OP_OR;
            F3_AND:  op = OP_AND;
            default: op = OP_ADD;
        endcase
    end

endmodule

// File: rtl/imm_alu_shift.sv
// Module: imm_alu_shift
// Logarithmic barrel shifter serving left, logical-right and
// arithmetic-right shifts with one right-shifting network. A left shift
// reverses the operand before and after the network. Combinational;
// assumes XLEN is a power of two.
module imm_alu_shift #(
    parameter int unsigned XLEN = 32,
    localparam int unsigned SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] din,
    input  logic [SHW-1:0]  amount,
    input  logic            left,
    input  logic            arith,
    output logic [XLEN-1:0] dout
);

    logic [XLEN-1:0] stage [SHW+1];
    logic            fill;
    logic [XLEN-1:0] rev_in;
    logic [XLEN-1:0] rev_out;

    // Operand reversal so that a left shift reuses the right network.
    always_comb begin
        for (int b = 0; b < XLEN; b++) begin
            rev_in[b] = din[XLEN-1-b];
        end
        stage[0] = left ? rev_in : din;
        fill     = arith & ~left & din[XLEN-1];
    end

    // One network stage per bit of the shift amount.
    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int unsigned DIST = 1 << s;
        always_comb begin
            stage[s+1] = amount[s]
                ? {{DIST{fill}}, stage[s][XLEN-1:DIST]}
                : stage[s];
        end
    end

    // Undo the reversal for left shifts.
    always_comb begin
        for (int b = 0; b < XLEN; b++) begin
            rev_out[b] = stage[SHW][XLEN-1-b];
        end
        dout = left ? rev_out : stage[SHW];
    end

endmodule

// File: rtl/imm_alu_core.sv
// Module: imm_alu_core
// Computes the result of one register-immediate operation from the source
// value, the sign-extended immediate and the shift amount. Combinational;
// assumes `op` comes from imm_alu_decode.
module imm_alu_core
    import imm_alu_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    localparam int unsigned SHW = $clog2(XLEN)
) (
    input  alu_op_e          op,
    input  logic [XLEN-1:0]  src,
    input  logic [XLEN-1:0]  imm,
    input  logic [SHW-1:0]   shamt,
    output logic [XLEN-1:0]  result
);

    logic [XLEN-1:0] shifted;
    logic            lt_signed;
    logic            lt_unsigned;

    imm_alu_shift #(.XLEN(XLEN)) u_shift (
        .din    (src),
        .amount (shamt),
        .left   (op == OP_SLL),
        .arith  (op == OP_SRA),
        .dout   (shifted)
    );

    // Both comparisons, formed once and shared by the selector.
    always_comb begin
        lt_unsigned = (src < imm);
        lt_signed   = (src[XLEN-1] != imm[XLEN-1]) ? src[XLEN-1] : lt_unsigned;
    end

    // Result selection by operation.
    always_comb begin
        unique case (op)
            OP_ADD:          result = src + imm;
            OP_SLL, OP_SRL,
            OP_SRA:          result = shifted;
            OP_SLT:          result = {{(XLEN-1){1'b0}}, lt_signed};
            OP_SLTU:         result = {{(XLEN-1){1'b0}}, lt_unsigned};
            OP_XOR:          result = src ^ imm;
            OP_OR:           result = src | imm;
            OP_AND:          result = src & imm;
            default:         result = '0;
        endcase
    end

endmodule

// File: rtl/imm_alu_stage.sv
// Module: imm_alu_stage (top)
// Execute stage for register-immediate integer instructions. Claims only
// the register-immediate opcode, registers the result one cycle later, and
// turns undefined shift encodings into a precise trap without writeback.
// Assumes a synchronous active-low reset and one instruction per cycle.
module imm_alu_stage
    import imm_alu_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned RIDX_W = 5,
    localparam int unsigned SHW   = $clog2(XLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ILEN-1:0]   in_instr,
    input  logic [XLEN-1:0]   in_pc,
    input  logic [XLEN-1:0]   in_rs1_val,
    output logic              out_valid,
    output logic [RIDX_W-1:0] out_rd,
    output logic              out_wen,
    output logic [XLEN-1:0]   out_result,
    output logic              out_trap,
    output logic [XLEN-1:0]   out_trap_pc,
    output logic [ILEN-1:0]   out_trap_instr
);

    logic              dec_claim;
    logic              dec_legal;
    alu_op_e           dec_op;
    logic [XLEN-1:0]   dec_imm;
    logic [SHW-1:0]    dec_shamt;
    logic [RIDX_W-1:0] dec_rd;
    logic [XLEN-1:0]   alu_result;
    logic              accept;

    imm_alu_decode #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_decode (
        .instr (in_instr),
        .claim (dec_claim),
        .legal (dec_legal),
        .op    (dec_op),
        .imm   (dec_imm),
        .shamt (dec_shamt),
        .rd    (dec_rd)
    );

    imm_alu_core #(.XLEN(XLEN)) u_core (
        .op     (dec_op),
        .src    (in_rs1_val),
        .imm    (dec_imm),
        .shamt  (dec_shamt),
        .result (alu_result)
    );

    // Instruction is present and belongs to this unit.
    always_comb begin
        accept = in_valid & dec_claim;
    end

    // Control flags: cleared by reset, otherwise follow the accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_wen   <= 1'b0;
            out_trap  <= 1'b0;
        end else begin
            out_valid <= accept;
            out_wen   <= accept & dec_legal & (dec_rd != '0);
            out_trap  <= accept & ~dec_legal;
        end
    end

    // Payload registers: loaded only when a word is accepted.
    always_ff @(posedge clk) begin
        if (accept) begin
            out_rd         <= dec_rd;
            out_result     <= alu_result;
            out_trap_pc    <= in_pc;
            out_trap_instr <= in_instr;
        end
    end

endmodule

// File: rtl/imm_alu_stage_chk.sv
// Module: imm_alu_stage_chk
// Property checker bound to imm_alu_stage. Assumes inputs are known values
// at every clock edge once reset is released.
module imm_alu_stage_chk
    import imm_alu_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned RIDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ILEN-1:0]   in_instr,
    input logic [XLEN-1:0]   in_pc,
    input logic              out_valid,
    input logic [RIDX_W-1:0] out_rd,
    input logic              out_wen,
    input logic [XLEN-1:0]   out_result,
    input logic              out_trap,
    input logic [XLEN-1:0]   out_trap_pc,
    input logic [ILEN-1:0]   out_trap_instr
);

    AST_TRAP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (out_valid && !out_wen)); // R8

    AST_TRAP_CARRIES_PC: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (out_trap_pc == $past(in_pc) && out_trap_instr == $past(in_instr))); // R8

    AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_wen |-> out_valid); // R12

    AST_ZERO_DEST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_rd == '0) |-> !out_wen); // R10

    AST_FOREIGN_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[6:0] != OPC_REG_IMM) |=> (!out_valid && !out_trap && !out_wen)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_trap && !out_wen)); // R11

    AST_COMPARE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_trap && ($past(in_instr[14:12]) == F3_SLT || $past(in_instr[14:12]) == F3_SLTU))
        |-> (out_result[XLEN-1:1] == '0)); // R3

endmodule

bind imm_alu_stage imm_alu_stage_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_instr       (in_instr),
    .in_pc          (in_pc),
    .out_valid      (out_valid),
    .out_rd         (out_rd),
    .out_wen        (out_wen),
    .out_result     (out_result),
    .out_trap       (out_trap),
    .out_trap_pc    (out_trap_pc),
    .out_trap_instr (out_trap_instr)
);

// File: tb/imm_alu_stage_bench.sv
// Bench: sweeps every minor code against a set of source values, immediates
// and shift encodings; expected values are computed arithmetically here.
module imm_alu_stage_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = 32'h0000_0013;
    logic [31:0] in_pc = '0;
    logic [31:0] in_rs1_val = '0;
    logic        out_valid;
    logic [4:0]  out_rd;
    logic        out_wen;
    logic [31:0] out_result;
    logic        out_trap;
    logic [31:0] out_trap_pc;
    logic [31:0] out_trap_instr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5ns clk = ~clk;

    imm_alu_stage u_imm_alu_stage (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_instr       (in_instr),
        .in_pc          (in_pc),
        .in_rs1_val     (in_rs1_val),
        .out_valid      (out_valid),
        .out_rd         (out_rd),
        .out_wen        (out_wen),
        .out_result     (out_result),
        .out_trap       (out_trap),
        .out_trap_pc    (out_trap_pc),
        .out_trap_instr (out_trap_instr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] src_pick(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7fff_ffff;
            3: return 32'h8000_0000;
            4: return 32'hffff_ffff;
            5: return 32'h1234_5678;
            6: return 32'hdead_beef;
            default: return 32'h0000_0fff;
        endcase
    endfunction

    function automatic logic [11:0] imm_pick(input int k);
        case (k)
            0: return 12'h000;
            1: return 12'h001;
            2: return 12'h7ff;
            3: return 12'h800;
            4: return 12'hfff;
            5: return 12'hffe;
            default: return 12'((k * 397) ^ (k << 7));
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] f3);
        case (f3)
            3'b000: return "R2";
            3'b010: return "R3";
            3'b011: return "R4";
            3'b001: return "R6";
            3'b101: return "R7";
            default: return "R5";
        endcase
    endfunction

    // Apply one claimed word and compare all outputs one edge later.
    task automatic apply(input logic [11:0] top12, input logic [2:0] f3,
                         input logic [4:0] rd, input logic [31:0] src,
                         input logic [31:0] pc);
        logic [31:0] word;
        logic [31:0] simm;
        logic [4:0]  sh;
        logic [6:0]  f7;
        logic        bad;
        logic [31:0] exp;
        string       tg;
        word = {top12, 5'd7, f3, rd, 7'b0010011};
        simm = {{20{top12[11]}}, top12};
        sh   = top12[4:0];
        f7   = top12[11:5];
        bad  = 1'b0;
        case (f3)
            3'b000: exp = src + simm;
            3'b010: exp = ($signed(src) < $signed(simm)) ? 32'd1 : 32'd0;
            3'b011: exp = (src < simm) ? 32'd1 : 32'd0;
            3'b100: exp = src ^ simm;
            3'b110: exp = src | simm;
            3'b111: exp = src & simm;
            3'b001: begin
                exp = src << sh;
                bad = (f7 != 7'h00);
            end
            default: begin
                exp = (f7 == 7'h20) ? 32'($signed(src) >>> sh) : (src >> sh);
                bad = (f7 != 7'h00) && (f7 != 7'h20);
            end
        endcase
        tg = tag_of(f3);
        in_valid = 1'b1; in_instr = word; in_pc = pc; in_rs1_val = src;
        @(posedge clk); #1;
        check(out_valid === 1'b1, bad ? "R8" : "R12", "out_valid", {31'd0, out_valid}, 32'd1);
        check(out_trap === bad, bad ? "R8" : "R12", "out_trap", {31'd0, out_trap}, {31'd0, bad});
        check(out_wen === (!bad && rd != 0), bad ? "R8" : (rd == 0 ? "R10" : "R12"), "out_wen",
              {31'd0, out_wen}, {31'd0, (!bad && rd != 0)});
        if (bad) begin
            check(out_trap_pc === pc, "R8", "out_trap_pc", out_trap_pc, pc);
            check(out_trap_instr === word, "R8", "out_trap_instr", out_trap_instr, word);
        end else begin
            check(out_result === exp, tg, "out_result", out_result, exp);
            check(out_rd === rd, "R12", "out_rd", {27'd0, out_rd}, {27'd0, rd});
        end
    endtask

    // Apply a cycle that must leave every output flag low.
    task automatic apply_quiet(input logic v, input logic [6:0] opc, input string req);
        in_valid = v; in_instr = {20'h00123, 5'd3, opc}; in_pc = 32'h40; in_rs1_val = 32'h5;
        @(posedge clk); #1;
        check(out_valid === 1'b0, req, "out_valid", {31'd0, out_valid}, 32'd0);
        check(out_wen === 1'b0, req, "out_wen", {31'd0, out_wen}, 32'd0);
        check(out_trap === 1'b0, req, "out_trap", {31'd0, out_trap}, 32'd0);
    endtask

    initial begin
        int vec;
        vec = 0;
        // R1: reset dominates a valid claimed input.
        in_valid = 1'b1; in_instr = 32'h0050_0093; in_rs1_val = 32'h1;
        repeat (3) @(posedge clk);
        #1;
        check(out_valid === 1'b0, "R1", "out_valid in reset", {31'd0, out_valid}, 32'd0);
        check(out_wen === 1'b0, "R1", "out_wen in reset", {31'd0, out_wen}, 32'd0);
        check(out_trap === 1'b0, "R1", "out_trap in reset", {31'd0, out_trap}, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); #1;

        for (int s = 0; s < 8; s++) begin
            for (int f = 0; f < 8; f++) begin
                if (f == 1 || f == 5) begin
                    for (int g = 0; g < 4; g++) begin
                        for (int a = 0; a < 32; a++) begin
                            logic [6:0] f7;
                            f7 = (g == 0) ? 7'h00 : (g == 1) ? 7'h20 : (g == 2) ? 7'h01 : 7'h40;
                            apply({f7, 5'(a)}, 3'(f), 5'(vec), src_pick(s), 32'h1000 + 32'(vec) * 4);
                            vec++;
                        end
                    end
                end else begin
                    for (int k = 0; k < 32; k++) begin
                        apply(imm_pick(k), 3'(f), 5'(vec), src_pick(s), 32'h1000 + 32'(vec) * 4);
                        vec++;
                    end
                end
            end
        end

        // R9: other major opcodes are ignored.
        apply_quiet(1'b1, 7'b0110011, "R9");
        apply_quiet(1'b1, 7'b0000011, "R9");
        apply_quiet(1'b1, 7'b1100011, "R9");
        apply_quiet(1'b1, 7'b0010111, "R9");
        // R11: idle cycle with a claimed opcode on the bus.
        apply_quiet(1'b0, 7'b0010011, "R11");
        // R8 after idle: an illegal shift right still traps.
        apply(12'h7e3, 3'b101, 5'd9, 32'h8000_0001, 32'hfff0);
        apply_quiet(1'b0, 7'b0010011, "R11");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2ms;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule